// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a bank of 32-bit control words behind a simple word-addressed request port. Each access carries a 12-bit byte address, so the decoded window is 4 KiB, and a size code. Only word-sized accesses on a 4-byte boundary are accepted. The word index is the byte address shifted right by two. Words 0 to `NUM_WORDS-1` exist. Any access above that range reads as zero and cannot be written.

Most of the control words below offset 0x104 are guarded. A write to offset 0x000 compares the data with the `UNLOCK_KEY` parameter and stores a single flag bit. While that flag is clear, writes into the guarded window are dropped. A small set of words is read-only. Offset 0x078 returns a new pseudo-random word on every read, produced by a 32-bit LFSR.

A strap word lives at 0x070. On the newer variant (`cfg_newer` = 1), a write there sets bits and a write to the revision offset 0x07C clears bits. On the older variant, 0x070 takes plain writes and 0x07C cannot be written. Reset loads a fixed default table that depends on the variant. Four words are loaded from input ports instead. Any rejected access raises a one-cycle error pulse.

Top module: `sysctl_regbank`

## Requirements
- R1: An access is well-formed only when `req_size` is 2 (word) and `req_addr[1:0]` is 0. A malformed access raises `err_pulse`, changes no word, and a malformed read returns 0.
- R2: A write to offset 0x000 stores 1 when `req_wdata` equals `UNLOCK_KEY` and 0 otherwise. Reading 0x000 returns only 0 or 1.
- R3: While the flag at 0x000 is 0, writes to offsets 0x004 through 0x100 are discarded and raise `err_pulse`. Offset 0x000 and offsets 0x104 upward can always be written.
- R4: Offsets 0x014, 0x050–0x06C, 0x078, 0x0E0 and 0x0E4 are read-only. A write to any of them changes nothing and raises `err_pulse`.
- R5: Each read of offset 0x078 returns a nonzero value that differs from the previous read of that offset. This holds whatever has been written to 0x074.
- R6: With `cfg_newer` = 1, a write to 0x070 ORs the data into the strap word. A write to 0x07C clears every strap bit that is 1 in the data and leaves the revision word unchanged.
- R7: With `cfg_newer` = 0, a write to 0x070 replaces the strap word. A write to 0x07C is ignored and raises `err_pulse`.
- R8: After reset, the words at 0x070, 0x07C and 0x0D0 hold `strap_a_init`, `rev_init` and `strap_b_init`, and the flag at 0x000 holds `key_init`. Every other word holds its variant default, for example 0x008 = F3F40000, 0x024 = 93000400 (newer) or 00000291 (older), 0x08C = 00000000 (newer) or 000000FF (older), 0x0E4 = FF, 0x104 = 80000000 and 0x1A4 = 2402. Unlisted words hold 0. `rsp_valid` and `err_pulse` are low during reset.
- R9: An access to a word index at or above `NUM_WORDS` (default 106, so first invalid offset 0x1A8) raises `err_pulse`. Such a read returns 0 and such a write is ignored.
- R10: `rsp_valid` is high exactly in the cycle after a read request and carries `rsp_rdata`. `err_pulse` is high only in the cycle after a rejected request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_newer | input | 1 | Variant select: 1 = newer set/clear strap behaviour |
| strap_a_init | input | 32 | Reset value of strap word 0x070 |
| strap_b_init | input | 32 | Reset value of strap word 0x0D0 |
| rev_init | input | 32 | Reset value of revision word 0x07C |
| key_init | input | 1 | Reset value of the unlock flag |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code, 2 = 32-bit word |
| req_addr | input | 12 | Byte address in the 4 KiB window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, cycle after a read |
| rsp_rdata | output | 32 | Read data |
| err_pulse | output | 1 | One-cycle pulse for a rejected access |

## Verification
The hardest state to reach is the strap word after a mix of set and clear writes on the newer variant. The clear path goes through the revision offset, which is itself guarded, so the bench must first unlock. It then ORs new bits into a port-supplied strap value, clears a mask through 0x07C, and reads both words back to show that only the strap changed. The bench then resets into the older variant to show the same offsets behaving as plain write and rejected write. It relocks and probes the last guarded word and the first unguarded word on either side of the window boundary.

// File: rtl/sysctl_pkg.sv
// Package: shared constants, access classes and the reset-default table
// for the key-locked system control register bank.
// Assumes a fixed 4 KiB window of 32-bit words (10-bit word index).
package sysctl_pkg;

    localparam int IDX_W      = 10;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam logic [1:0] SIZE_WORD = 2'd2;

    // Word indices whose behaviour depends on their position
    localparam logic [IDX_W-1:0] IX_KEY     = 10'd0;   // 0x000
    localparam logic [IDX_W-1:0] IX_LOCK_HI = 10'd64;  // 0x100, last guarded word
    localparam logic [IDX_W-1:0] IX_STRAPA  = 10'd28;  // 0x070
    localparam logic [IDX_W-1:0] IX_RNG     = 10'd30;  // 0x078
    localparam logic [IDX_W-1:0] IX_REV     = 10'd31;  // 0x07C
    localparam logic [IDX_W-1:0] IX_STRAPB  = 10'd52;  // 0x0D0

    typedef enum logic [2:0] {
        WK_NONE,
        WK_KEY,
        WK_PLAIN,
        WK_SET,
        WK_CLR
    } wr_kind_t;

    // Words that never accept writes on either variant
    function automatic logic is_read_only(input logic [IDX_W-1:0] ix);
        return (ix == 10'd5) || (ix >= 10'd20 && ix <= 10'd27) ||
               (ix == IX_RNG) || (ix == 10'd56) || (ix == 10'd57);
    endfunction

    // Variant-dependent reset default of one word, selected by byte offset
    function automatic logic [DATA_W-1:0] default_word(input logic [IDX_W-1:0] ix,
                                                       input logic newer);
        logic [ADDR_W-1:0] off;
        off = {ix, 2'b00};
        case (off)
            12'h004: return 32'hFFCF_FEDC;
            12'h008: return 32'hF3F4_0000;
            12'h00C: return 32'h19FC_3E8B;
            12'h01C: return 32'h0002_6108;
            12'h020: return 32'h0003_0291;
            12'h024: return newer ? 32'h9300_0400 : 32'h0000_0291;
            12'h02C: return 32'h0000_0010;
            12'h030: return 32'h2000_1A03;
            12'h034: return 32'h2000_1A03;
            12'h038: return 32'h0400_0030;
            12'h03C: return 32'h0000_0001;
            12'h040: return 32'h0000_00C0;
            12'h04C: return 32'h0000_0023;
            12'h074: return 32'h0000_000E;
            12'h084: return 32'h0000_F000;
            12'h088: return newer ? 32'h0300_0000 : 32'h0100_0000;
            12'h08C: return newer ? 32'h0000_0000 : 32'h0000_00FF;
            12'h090: return 32'h0000_A000;
            12'h09C: return newer ? 32'h023F_FFF3 : 32'h003F_FFF3;
            12'h0A4: return 32'hFFFF_0000;
            12'h0A8: return 32'h000F_FFFF;
            12'h0E0: return 32'h0000_00FF;
            12'h0E4: return 32'h0000_00FF;
            12'h104: return 32'h8000_0000;
            12'h110: return 32'h1E60_0000;
            12'h114: return 32'hC000_0000;
            12'h160: return 32'h0000_1903;
            12'h180: return 32'h0000_007B;
            12'h1A4: return 32'h0000_2402;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_lfsr.sv
// Module: 32-bit Galois LFSR used as the pseudo-random read source.
// Assumes SEED is nonzero; the state advances by one step when step is high.
module sysctl_lfsr #(
    parameter int          WIDTH = 32,
    parameter logic [31:0] TAPS  = 32'hA300_0000,
    parameter logic [31:0] SEED  = 32'h1D87_2B41
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [WIDTH-1:0] value
);
    logic [WIDTH-1:0] state;

    // Advance the shift register on each requested step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED[WIDTH-1:0];
        end else if (step) begin
            state <= {1'b0, state[WIDTH-1:1]} ^ (state[0] ? TAPS[WIDTH-1:0] : '0);
        end
    end

    assign value = state;
endmodule

// File: rtl/sysctl_access_policy.sv
// Module: classifies one bus request into accept/reject and a write kind.
// Assumes requests last one cycle; purely combinational.
module sysctl_access_policy
    import sysctl_pkg::*;
#(
    parameter int NUM_WORDS = 106
) (
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [1:0]            req_size,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  key_open,
    input  logic                  newer,
    output logic [IDX_W-1:0]      word_ix,
    output logic [IDX_W-1:0]      target_ix,
    output wr_kind_t              wr_kind,
    output logic                  rd_go,
    output logic                  rd_rng,
    output logic                  reject
);
    localparam logic [IDX_W-1:0] LAST_IX = IDX_W'(NUM_WORDS - 1);

    logic shape_ok, in_range, guarded, ro_hit;

    // Decode the shape, range and per-word policy of the request
    always_comb begin
        word_ix  = req_addr[ADDR_W-1:2];
        shape_ok = (req_size == SIZE_WORD) && (req_addr[1:0] == 2'b00);
        in_range = (word_ix <= LAST_IX);
        guarded  = !key_open && (word_ix != IX_KEY) && (word_ix <= IX_LOCK_HI);
        ro_hit   = is_read_only(word_ix) || (word_ix == IX_REV && !newer);
    end

    // Pick the action taken for the request
    always_comb begin
        target_ix = word_ix;
        wr_kind   = WK_NONE;
        rd_go     = 1'b0;
        rd_rng    = 1'b0;
        reject    = 1'b0;
        if (req_valid) begin
            if (!req_write) begin
                reject = !shape_ok || !in_range;
                rd_go  = !reject;
                rd_rng = !reject && (word_ix == IX_RNG);
            end else begin
                reject = !shape_ok || !in_range || guarded || ro_hit;
                if (!reject) begin
                    if (word_ix == IX_KEY) begin
                        wr_kind = WK_KEY;
                    end else if (word_ix == IX_STRAPA && newer) begin
                        wr_kind = WK_SET;
                    end else if (word_ix == IX_REV) begin
                        wr_kind   = WK_CLR;
                        target_ix = IX_STRAPA;
                    end else begin
                        wr_kind = WK_PLAIN;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sysctl_regbank.sv
// Module: top of the key-locked system control register bank.
// Assumes cfg_newer is static between resets and one request per cycle at most.
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int          NUM_WORDS  = 106,
    parameter logic [31:0] UNLOCK_KEY = 32'hC0DE_5A17,
    parameter logic [31:0] RNG_SEED   = 32'h1D87_2B41
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_newer,
    input  logic [DATA_W-1:0]    strap_a_init,
    input  logic [DATA_W-1:0]    strap_b_init,
    input  logic [DATA_W-1:0]    rev_init,
    input  logic                 key_init,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_size,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 err_pulse
);
    logic [DATA_W-1:0] words [NUM_WORDS];
    logic              key_open;
    logic [IDX_W-1:0]  word_ix, target_ix;
    wr_kind_t          wr_kind;
    logic              rd_go, rd_rng, reject;
    logic [DATA_W-1:0] rng_value;
    logic [DATA_W-1:0] rd_word;

    assign key_open = words[0][0];

    sysctl_access_policy #(.NUM_WORDS(NUM_WORDS)) u_policy (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .key_open  (key_open),
        .newer     (cfg_newer),
        .word_ix   (word_ix),
        .target_ix (target_ix),
        .wr_kind   (wr_kind),
        .rd_go     (rd_go),
        .rd_rng    (rd_rng),
        .reject    (reject)
    );

    sysctl_lfsr #(.WIDTH(DATA_W), .SEED(RNG_SEED)) u_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (rd_rng),
        .value (rng_value)
    );

    // Load defaults on reset, then apply the accepted write to its target word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (IDX_W'(i) == IX_KEY)         words[i] <= {31'd0, key_init};
                else if (IDX_W'(i) == IX_STRAPA) words[i] <= strap_a_init;
                else if (IDX_W'(i) == IX_REV)    words[i] <= rev_init;
                else if (IDX_W'(i) == IX_STRAPB) words[i] <= strap_b_init;
                else                             words[i] <= default_word(IDX_W'(i), cfg_newer);
            end
        end else begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (target_ix == IDX_W'(i)) begin
                    case (wr_kind)
                        WK_KEY:   words[i] <= {31'd0, req_wdata == UNLOCK_KEY};
                        WK_PLAIN: words[i] <= req_wdata;
                        WK_SET:   words[i] <= words[i] | req_wdata;
                        WK_CLR:   words[i] <= words[i] & ~req_wdata;
                        default:  ;
                    endcase
                end
            end
        end
    end

    // Select the word returned for an accepted read
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (word_ix == IDX_W'(i)) rd_word = words[i];
        end
        if (rd_rng) rd_word = rng_value;
    end

    // Register the response and the error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            err_pulse <= 1'b0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_rdata <= rd_go ? rd_word : '0;
            err_pulse <= reject;
        end
    end
endmodule

// File: rtl/sysctl_regbank_chk.sv
// Module: protocol checker bound to sysctl_regbank; observes ports and the unlock flag.
// Assumes the default 4 KiB window and the guarded range 0x004..0x100.
module sysctl_regbank_chk #(
    parameter int NUM_WORDS = 106
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  req_size,
    input logic [11:0] req_addr,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        err_pulse,
    input logic        key_open
);
    p_bad_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_size != 2'd2 || req_addr[1:0] != 2'b00)) |=> err_pulse);

    p_key_binary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 2'd2 && req_addr == 12'h000)
        |=> (rsp_rdata[31:1] == 31'd0));

    p_key_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && req_size == 2'd2 && req_addr == 12'h000)
        |=> $stable(key_open));

    p_locked_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !key_open &&
         req_addr[11:2] >= 10'd1 && req_addr[11:2] <= 10'd64) |=> err_pulse);

    p_oor_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[11:2] >= 10'(NUM_WORDS)) |=> err_pulse);

    p_oor_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[11:2] >= 10'(NUM_WORDS))
        |=> (rsp_rdata == 32'd0));

    p_err_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(req_valid));

    p_rsp_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));
endmodule

bind sysctl_regbank sysctl_regbank_chk #(.NUM_WORDS(NUM_WORDS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .err_pulse (err_pulse),
    .key_open  (key_open)
);

// File: tb/tb_sysctl_regbank.sv
// Bench: vector walk on the newer variant, then directed random-source and older-variant tests.
module tb_sysctl_regbank;
    localparam logic [31:0] TB_KEY = 32'hC0DE_5A17;
    localparam logic [31:0] SA = 32'h0000_1234;
    localparam logic [31:0] SB = 32'h0000_00AB;
    localparam logic [31:0] RV = 32'h0403_0303;

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [11:0] addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        er;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 41;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd2, 12'h000, 32'h0,          32'h0,          1'b0, 4'd8},  // R8 key_init
        '{1'b0, 2'd2, 12'h008, 32'h0,          32'hF3F4_0000,  1'b0, 4'd8},  // R8
        '{1'b0, 2'd2, 12'h024, 32'h0,          32'h9300_0400,  1'b0, 4'd8},  // R8 newer
        '{1'b0, 2'd2, 12'h104, 32'h0,          32'h8000_0000,  1'b0, 4'd8},  // R8
        '{1'b0, 2'd2, 12'h070, 32'h0,          SA,             1'b0, 4'd8},  // R8
        '{1'b0, 2'd2, 12'h0D0, 32'h0,          SB,             1'b0, 4'd8},  // R8
        '{1'b0, 2'd2, 12'h07C, 32'h0,          RV,             1'b0, 4'd8},  // R8
        '{1'b1, 2'd2, 12'h008, 32'h1111,       32'h0,          1'b1, 4'd3},  // R3 locked
        '{1'b0, 2'd2, 12'h008, 32'h0,          32'hF3F4_0000,  1'b0, 4'd3},  // R3
        '{1'b1, 2'd2, 12'h104, 32'hAAAA_5555,  32'h0,          1'b0, 4'd3},  // R3 open
        '{1'b0, 2'd2, 12'h104, 32'h0,          32'hAAAA_5555,  1'b0, 4'd3},  // R3
        '{1'b1, 2'd2, 12'h000, 32'h1234_5678,  32'h0,          1'b0, 4'd2},  // R2 wrong key
        '{1'b0, 2'd2, 12'h000, 32'h0,          32'h0,          1'b0, 4'd2},  // R2
        '{1'b1, 2'd2, 12'h000, TB_KEY,         32'h0,          1'b0, 4'd2},  // R2 key
        '{1'b0, 2'd2, 12'h000, 32'h0,          32'h1,          1'b0, 4'd2},  // R2
        '{1'b1, 2'd2, 12'h008, 32'h1111,       32'h0,          1'b0, 4'd3},  // R3 unlocked
        '{1'b0, 2'd2, 12'h008, 32'h0,          32'h1111,       1'b0, 4'd3},  // R3
        '{1'b1, 2'd2, 12'h014, 32'hFFFF,       32'h0,          1'b1, 4'd4},  // R4
        '{1'b0, 2'd2, 12'h014, 32'h0,          32'h0,          1'b0, 4'd4},  // R4
        '{1'b1, 2'd2, 12'h058, 32'h1,          32'h0,          1'b1, 4'd4},  // R4
        '{1'b0, 2'd2, 12'h058, 32'h0,          32'h0,          1'b0, 4'd4},  // R4
        '{1'b1, 2'd2, 12'h0E4, 32'h7,          32'h0,          1'b1, 4'd4},  // R4
        '{1'b0, 2'd2, 12'h0E4, 32'h0,          32'hFF,         1'b0, 4'd4},  // R4
        '{1'b1, 2'd2, 12'h070, 32'hF000,       32'h0,          1'b0, 4'd6},  // R6 set
        '{1'b0, 2'd2, 12'h070, 32'h0,          32'hF234,       1'b0, 4'd6},  // R6
        '{1'b1, 2'd2, 12'h07C, 32'h0204,       32'h0,          1'b0, 4'd6},  // R6 clear
        '{1'b0, 2'd2, 12'h070, 32'h0,          32'hF030,       1'b0, 4'd6},  // R6
        '{1'b0, 2'd2, 12'h07C, 32'h0,          RV,             1'b0, 4'd6},  // R6 rev kept
        '{1'b0, 2'd2, 12'h1A4, 32'h0,          32'h2402,       1'b0, 4'd9},  // R9 last word
        '{1'b0, 2'd2, 12'h1A8, 32'h0,          32'h0,          1'b1, 4'd9},  // R9
        '{1'b1, 2'd2, 12'h1A8, 32'h1,          32'h0,          1'b1, 4'd9},  // R9
        '{1'b0, 2'd2, 12'hFFC, 32'h0,          32'h0,          1'b1, 4'd9},  // R9
        '{1'b1, 2'd1, 12'h104, 32'h12,         32'h0,          1'b1, 4'd1},  // R1 size
        '{1'b1, 2'd2, 12'h106, 32'h12,         32'h0,          1'b1, 4'd1},  // R1 align
        '{1'b0, 2'd2, 12'h104, 32'h0,          32'hAAAA_5555,  1'b0, 4'd1},  // R1
        '{1'b0, 2'd0, 12'h104, 32'h0,          32'h0,          1'b1, 4'd1},  // R1 bad read
        '{1'b1, 2'd2, 12'h000, 32'h0,          32'h0,          1'b0, 4'd3},  // R3 relock
        '{1'b1, 2'd2, 12'h100, 32'h5,          32'h0,          1'b1, 4'd3},  // R3 edge
        '{1'b0, 2'd2, 12'h100, 32'h0,          32'h0,          1'b0, 4'd3},  // R3
        '{1'b1, 2'd2, 12'h1A0, 32'h9,          32'h0,          1'b0, 4'd3},  // R3 open
        '{1'b0, 2'd2, 12'h1A0, 32'h0,          32'h9,          1'b0, 4'd3}   // R3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_newer = 1'b1;
    logic [31:0] strap_a_init = SA, strap_b_init = SB, rev_init = RV;
    logic        key_init = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'd2;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, err_pulse;
    logic [31:0] rsp_rdata;

    int n_checks = 0, n_fail = 0;
    logic        got_err, got_vld;
    logic [31:0] got_data;

    always #10 clk = ~clk;

    sysctl_regbank #(.UNLOCK_KEY(TB_KEY)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_newer(cfg_newer),
        .strap_a_init(strap_a_init), .strap_b_init(strap_b_init),
        .rev_init(rev_init), .key_init(key_init),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_pulse(err_pulse)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One access: drive at a falling edge, sample at the next falling edge
    task automatic access(input logic wr, input logic [1:0] sz, input logic [11:0] a,
                          input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        got_err = err_pulse; got_vld = rsp_valid; got_data = rsp_rdata;
    endtask

    task automatic do_reset(input logic newer, input logic key);
        @(negedge clk);
        rst_n = 1'b0; cfg_newer = newer; key_init = key;
        repeat (3) @(negedge clk);
        check("R8 reset rsp_valid low", {31'd0, rsp_valid}, 32'd0);
        check("R8 reset err low", {31'd0, err_pulse}, 32'd0);
        rst_n = 1'b1;
    endtask

    logic [31:0] r0, r1, r2, r3;
    bit done = 1'b0;

    initial begin
        do_reset(1'b1, 1'b0);
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].sz, VECS[i].addr, VECS[i].wd);
            check($sformatf("R%0d vec %0d err", VECS[i].rq, i), {31'd0, got_err},
                  {31'd0, VECS[i].er});
            if (!VECS[i].wr) begin
                check($sformatf("R10 vec %0d rsp_valid", i), {31'd0, got_vld}, 32'd1);
                check($sformatf("R%0d vec %0d data", VECS[i].rq, i), got_data, VECS[i].exp);
            end else begin
                check($sformatf("R10 vec %0d no rsp on write", i), {31'd0, got_vld}, 32'd0);
            end
        end

        // R5: fresh random words, independent of the control word at 0x074
        access(1'b0, 2'd2, 12'h078, 0); r0 = got_data;
        access(1'b0, 2'd2, 12'h078, 0); r1 = got_data;
        access(1'b0, 2'd2, 12'h078, 0); r2 = got_data;
        check("R5 nonzero", {31'd0, (r0 != 0) && (r1 != 0) && (r2 != 0)}, 32'd1);
        check("R5 distinct", {31'd0, (r0 != r1) && (r1 != r2)}, 32'd1);
        access(1'b1, 2'd2, 12'h000, TB_KEY);
        access(1'b1, 2'd2, 12'h074, 32'h0);
        check("R5 ctrl write accepted", {31'd0, got_err}, 32'd0);
        access(1'b0, 2'd2, 12'h078, 0); r3 = got_data;
        check("R5 fresh after ctrl clear", {31'd0, (r3 != r2) && (r3 != 0)}, 32'd1);
        access(1'b1, 2'd2, 12'h078, 32'h5);
        check("R4 rng write rejected", {31'd0, got_err}, 32'd1);

        // Older variant
        do_reset(1'b0, 1'b1);
        access(1'b0, 2'd2, 12'h000, 0);
        check("R8 key_init=1", got_data, 32'd1);
        access(1'b0, 2'd2, 12'h024, 0);
        check("R8 older default 0x024", got_data, 32'h0000_0291);
        access(1'b0, 2'd2, 12'h08C, 0);
        check("R8 older default 0x08C", got_data, 32'h0000_00FF);
        access(1'b1, 2'd2, 12'h070, 32'h0000_F000);
        check("R7 plain strap write err", {31'd0, got_err}, 32'd0);
        access(1'b0, 2'd2, 12'h070, 0);
        check("R7 plain strap write", got_data, 32'h0000_F000);
        access(1'b1, 2'd2, 12'h07C, 32'hFFFF_FFFF);
        check("R7 rev write rejected", {31'd0, got_err}, 32'd1);
        access(1'b0, 2'd2, 12'h070, 0);
        check("R7 strap untouched", got_data, 32'h0000_F000);
        access(1'b0, 2'd2, 12'h07C, 0);
        check("R7 rev untouched", got_data, RV);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule